// File: doc/BRIEF.md
# ADC Conversion Trigger and Result Controller

This block is the digital sequencer around a 10-bit successive-approximation converter. It decides when a conversion starts and which input it samples. It then times the sampling window and hands the hold-and-convert step to the converter through a level request and a done pulse. When the converter finishes, the block captures the returned code into a result holder and raises the completion flags.

A conversion can be started in three ways: by a software start pulse, by a qualified edge on an external start pin, or by a pulse-width-modulator event. The pin edge is filtered for stability and the PWM event waits out a programmable delay. A conversion starts only while the converter enable is high and the block is idle. The channel is the lowest-numbered bit set in the channel mask. The sampling window length is chosen by a 4-bit code from a non-linear table. Reading the result clears its valid and overrun flags. The end-of-conversion flag is cleared by a write-one strobe and, together with the interrupt enable, drives the interrupt line.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A `sw_start` pulse sampled while `conv_en` is 1 and the block is idle sets `busy` on the next clock. `busy` stays 1 until the converter's done pulse is accepted. While `conv_en` is 0 no start is taken from any source.
- R2: With `hw_trig_en`=1 and `trig_sel`=0, a qualified edge on `start_pin` starts a conversion. The edge is rising when `edge_rise`=1 and falling when `edge_rise`=0, and the opposite edge is ignored. With `hw_trig_en`=0 the pin has no effect.
- R3: A new pin level is accepted only after it has held for 4 consecutive clocks at the synchronizer output, so a pulse of 2 clocks never starts a conversion.
- R4: With `hw_trig_en`=1 and `trig_sel`=3, a `pwm_trig` pulse sampled at clock edge E0 makes `conv_sample` go high after clock edge E0+4·`trig_dly`+1.
- R5: Clearing `hw_trig_en` while a PWM delay is counting cancels it, and no conversion follows.
- R6: When several bits of `chan_mask` are set, the lowest-numbered one is converted. Its number appears on `cur_chan` for the whole conversion.
- R7: A start with `chan_mask`=0 leaves `busy` at 0 and produces no sampling window, result or end-of-conversion flag.
- R8: `conv_sample` is high for exactly N clocks, where N comes from `smp_code`: codes 0..7 give 6, 7, 8, 10, 14, 22, 38, 70; code 8 gives 1346; codes 9, 10, 11 give 262, 518, 1030; codes 12..15 give 1030. `conv_go` is held high after the window until `conv_done`.
- R9: An accepted `conv_done` loads `conv_data` into `result` and sets `valid`. It also sets `overrun` if `valid` or `overrun` was still set. A `rd_strobe` clears both flags and leaves `result` unchanged.
- R10: `eoc_flag` is set by every completed conversion and cleared by an `eoc_clr` pulse. `irq` equals `eoc_flag` AND `irq_en`.
- R11: Start requests from any source that arrive while `busy` is 1 are ignored, so each accepted start gives exactly one sampling window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | Converter enable; gates every start |
| irq_en | input | 1 | Interrupt enable for end of conversion |
| hw_trig_en | input | 1 | Hardware trigger enable |
| trig_sel | input | 2 | Hardware source: 0 start pin, 3 PWM event |
| edge_rise | input | 1 | Pin polarity: 1 rising, 0 falling |
| trig_dly | input | 8 | PWM delay in steps of 4 clocks |
| smp_code | input | 4 | Sampling window length code |
| chan_mask | input | 12 | Channel enable mask |
| sw_start | input | 1 | Software start pulse |
| start_pin | input | 1 | Asynchronous external start pin |
| pwm_trig | input | 1 | PWM event pulse |
| rd_strobe | input | 1 | Result read pulse; clears valid and overrun |
| eoc_clr | input | 1 | Write-one clear for the end-of-conversion flag |
| conv_sample | output | 1 | Sampling window active |
| conv_go | output | 1 | Conversion request to the converter |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 10 | Converter result code |
| result | output | 10 | Held conversion result |
| valid | output | 1 | Unread result present |
| overrun | output | 1 | A result was overwritten unread |
| eoc_flag | output | 1 | End-of-conversion flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Conversion in progress (mirror of the start bit) |
| cur_chan | output | 4 | Channel of the current or last conversion |

## Verification
The hardest situations to reach are the timing-dependent trigger paths. One is a PWM delay that must be cancelled part-way through its count. The others are pin pulses that are just too short, or of the wrong polarity, to pass the filter. The stimulus drives these directly. It holds the pin for exact clock counts, drops the hardware enable a fixed number of cycles into a long delay, and counts cycles from the sampled PWM edge to the first sampling clock. Constrained-random rounds then vary the mask, the window code, reads and flag clears. A bench model of the flags predicts valid, overrun and the interrupt for each round.

// File: rtl/adc_ctl_pkg.sv
`timescale 1ns/1ps
package adc_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } ctl_state_e;

  localparam int SMP_W = 11;

  // Sampling window length in clocks for a 4-bit code.
  function automatic logic [SMP_W-1:0] smp_clocks(input logic [3:0] code);
    logic [SMP_W-1:0] len;
    if (code == 4'd8)
      len = SMP_W'(1346);
    else if (code >= 4'd12)
      len = SMP_W'(1030);
    else if (code == 4'd0)
      len = SMP_W'(6);
    else
      len = SMP_W'(6) + (SMP_W'(1) << (code - 4'd1));
    return len;
  endfunction

endpackage

// File: rtl/adc_pin_qual.sv
`timescale 1ns/1ps
module adc_pin_qual #(
  parameter int FILT = 4,
  localparam int CNTW = (FILT > 1) ? $clog2(FILT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_o
);

  logic            s1_q, s2_q;
  logic            lvl_q, lvl_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            edge_q, edge_d;

  always_comb begin
    lvl_d  = lvl_q;
    cnt_d  = cnt_q;
    edge_d = 1'b0;
    if (s2_q == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNTW'(FILT - 1)) begin
      lvl_d  = s2_q;
      cnt_d  = '0;
      edge_d = (s2_q == rise_sel);
    end else begin
      cnt_d = cnt_q + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
      edge_q <= 1'b0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
      edge_q <= edge_d;
    end
  end

  assign edge_o = edge_q;

  // R3: an accepted level change follows a run of equal synchronized samples
  a_r3_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |->
      ($past(s2_q) == $past(s2_q, 2)) && ($past(s2_q, 2) == $past(s2_q, 3)));

endmodule

// File: rtl/adc_pwm_delay.sv
`timescale 1ns/1ps
module adc_pwm_delay #(
  parameter int DLY_W = 8,
  localparam int CW = DLY_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             cancel,
  input  logic [DLY_W-1:0] dly,
  output logic             fire
);

  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign fire = pend_q && (cnt_q == '0);

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (cancel) begin
      pend_d = 1'b0;
    end else if (arm && !pend_q) begin
      pend_d = 1'b1;
      cnt_d  = {dly, 2'b00};
    end else if (pend_q) begin
      if (cnt_q == '0) pend_d = 1'b0;
      else             cnt_d  = cnt_q - CW'(1);
    end
  end

  assign cnt_en = cancel || arm || pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  // R5: a cancel leaves nothing pending
  a_r5_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !pend_q);

  // R4: a delay fires once and then is no longer pending
  a_r4_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pend_q);

endmodule

// File: rtl/adc_chan_pick.sv
`timescale 1ns/1ps
module adc_chan_pick #(
  parameter int NCH = 12,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  output logic           found,
  output logic [CW-1:0]  idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = CW'(i);
      end
    end
  end

endmodule

// File: rtl/adc_result_hold.sv
`timescale 1ns/1ps
module adc_result_hold #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [RES_W-1:0] data,
  input  logic             rd,
  input  logic             eoc_clr,
  output logic [RES_W-1:0] result,
  output logic             valid,
  output logic             overrun,
  output logic             eoc
);

  logic [RES_W-1:0] res_q;
  logic             val_q, val_d;
  logic             ovr_q, ovr_d;
  logic             eoc_q, eoc_d;

  always_comb begin
    if (load) begin
      val_d = 1'b1;
      ovr_d = (val_q || ovr_q) && !rd;
    end else if (rd) begin
      val_d = 1'b0;
      ovr_d = 1'b0;
    end else begin
      val_d = val_q;
      ovr_d = ovr_q;
    end
    if (load)         eoc_d = 1'b1;
    else if (eoc_clr) eoc_d = 1'b0;
    else              eoc_d = eoc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (load) begin
      res_q <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= 1'b0;
      ovr_q <= 1'b0;
      eoc_q <= 1'b0;
    end else begin
      val_q <= val_d;
      ovr_q <= ovr_d;
      eoc_q <= eoc_d;
    end
  end

  assign result  = res_q;
  assign valid   = val_q;
  assign overrun = ovr_q;
  assign eoc     = eoc_q;

  // R9: overrun is only ever reported alongside an unread result
  a_r9_ovr_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> valid);

  // R9: a read without a load clears both flags
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !load) |=> (!valid && !overrun));

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int NCH   = 12,
  parameter int RES_W = 10,
  parameter int DLY_W = 8,
  parameter int FILT  = 4,
  localparam int CW   = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_en,
  input  logic             irq_en,
  input  logic             hw_trig_en,
  input  logic [1:0]       trig_sel,
  input  logic             edge_rise,
  input  logic [DLY_W-1:0] trig_dly,
  input  logic [3:0]       smp_code,
  input  logic [NCH-1:0]   chan_mask,
  input  logic             sw_start,
  input  logic             start_pin,
  input  logic             pwm_trig,
  input  logic             rd_strobe,
  input  logic             eoc_clr,
  output logic             conv_sample,
  output logic             conv_go,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic [RES_W-1:0] result,
  output logic             valid,
  output logic             overrun,
  output logic             eoc_flag,
  output logic             irq,
  output logic             busy,
  output logic [CW-1:0]    cur_chan
);

  localparam logic [1:0] SEL_PIN = 2'd0;
  localparam logic [1:0] SEL_PWM = 2'd3;

  ctl_state_e       state_q, state_d;
  logic [SMP_W-1:0] smp_q, smp_d;
  logic [CW-1:0]    chan_q, chan_d;
  logic             idle;
  logic             pin_edge;
  logic             dly_fire, dly_arm, dly_cancel;
  logic             pick_found;
  logic [CW-1:0]    pick_idx;
  logic             start_req, start_ok;
  logic             res_load;

  assign idle = (state_q == ST_IDLE);

  adc_pin_qual #(.FILT(FILT)) u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (start_pin),
    .rise_sel (edge_rise),
    .edge_o   (pin_edge)
  );

  assign dly_arm    = pwm_trig && hw_trig_en && (trig_sel == SEL_PWM) && conv_en && idle;
  assign dly_cancel = !(hw_trig_en && (trig_sel == SEL_PWM) && conv_en);

  adc_pwm_delay #(.DLY_W(DLY_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (dly_arm),
    .cancel (dly_cancel),
    .dly    (trig_dly),
    .fire   (dly_fire)
  );

  adc_chan_pick #(.NCH(NCH)) u_pick (
    .mask  (chan_mask),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign start_req = sw_start
                   || (hw_trig_en && (trig_sel == SEL_PIN) && pin_edge)
                   || dly_fire;
  assign start_ok  = start_req && conv_en && idle && pick_found;

  always_comb begin
    state_d = state_q;
    smp_d   = smp_q;
    chan_d  = chan_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          state_d = ST_SAMPLE;
          smp_d   = smp_clocks(smp_code) - SMP_W'(1);
          chan_d  = pick_idx;
        end
      end
      ST_SAMPLE: begin
        if (smp_q == '0) state_d = ST_CONV;
        else             smp_d   = smp_q - SMP_W'(1);
      end
      ST_CONV: begin
        if (conv_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      smp_q   <= '0;
      chan_q  <= '0;
    end else begin
      state_q <= state_d;
      if (!idle || start_ok) smp_q <= smp_d;
      if (start_ok)          chan_q <= chan_d;
    end
  end

  assign conv_sample = (state_q == ST_SAMPLE);
  assign conv_go     = (state_q == ST_CONV);
  assign busy        = !idle;
  assign cur_chan    = chan_q;
  assign res_load    = conv_go && conv_done;

  adc_result_hold #(.RES_W(RES_W)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (res_load),
    .data    (conv_data),
    .rd      (rd_strobe),
    .eoc_clr (eoc_clr),
    .result  (result),
    .valid   (valid),
    .overrun (overrun),
    .eoc     (eoc_flag)
  );

  assign irq = eoc_flag && irq_en;

  // R1: a conversion only begins while the converter is enabled
  a_r1_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(conv_en));

  // R8: the converter request is preceded by the sampling window
  a_r8_sample_then_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_go) |-> $past(conv_sample));

  // R6: the picked channel is set in the mask and no lower one is
  a_r6_lowest_pick: assert property (@(posedge clk) disable iff (!rst_n)
    pick_found |-> (chan_mask[pick_idx] &&
      ((chan_mask & ((NCH'(1) << pick_idx) - NCH'(1))) == '0)));

  // R7: an empty mask never takes the block out of idle
  a_r7_empty_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && (chan_mask == '0)) |=> !busy);

  // R10: an accepted done sets the end-of-conversion flag
  a_r10_eoc_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_go && conv_done) |=> eoc_flag);

  // R11: no second sampling window starts without passing through idle
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_sample) |-> $past(idle));

endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;

  logic        clk;
  logic        rst_n;
  logic        conv_en, irq_en, hw_trig_en, edge_rise;
  logic [1:0]  trig_sel;
  logic [7:0]  trig_dly;
  logic [3:0]  smp_code;
  logic [11:0] chan_mask;
  logic        sw_start, start_pin, pwm_trig, rd_strobe, eoc_clr;
  logic        conv_sample, conv_go, conv_done;
  logic [9:0]  conv_data, result;
  logic        valid, overrun, eoc_flag, irq, busy;
  logic [3:0]  cur_chan;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  int nsamp = 0;
  int run = 0;
  int last_smp = 0;
  bit prev_s = 0;
  int ndone = 0;
  int lat = 2;
  logic [9:0] mdata = '0;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .irq_en(irq_en),
    .hw_trig_en(hw_trig_en), .trig_sel(trig_sel), .edge_rise(edge_rise),
    .trig_dly(trig_dly), .smp_code(smp_code), .chan_mask(chan_mask),
    .sw_start(sw_start), .start_pin(start_pin), .pwm_trig(pwm_trig),
    .rd_strobe(rd_strobe), .eoc_clr(eoc_clr), .conv_sample(conv_sample),
    .conv_go(conv_go), .conv_done(conv_done), .conv_data(conv_data),
    .result(result), .valid(valid), .overrun(overrun), .eoc_flag(eoc_flag),
    .irq(irq), .busy(busy), .cur_chan(cur_chan)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // converter model: answers conv_go after a short random latency
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      @(negedge clk);
      if (conv_done) begin
        conv_done = 1'b0;
      end else if (conv_go) begin
        if (lat == 0) begin
          ndone++;
          mdata = 10'((int'(cur_chan) * 37 + ndone * 11) % 1024);
          conv_data = mdata;
          conv_done = 1'b1;
          lat = int'($urandom % 4);
        end else begin
          lat--;
        end
      end
    end
  end

  // sampling window monitor
  initial begin
    forever begin
      @(negedge clk);
      if (conv_sample) run++;
      else if (run != 0) begin last_smp = run; run = 0; end
      if (conv_sample && !prev_s) nsamp++;
      prev_s = conv_sample;
    end
  end

  function automatic int exp_smp(input int code);
    case (code)
      0: return 6;     1: return 7;     2: return 8;     3: return 10;
      4: return 14;    5: return 22;    6: return 38;    7: return 70;
      8: return 1346;  9: return 262;   10: return 518;
      default: return 1030;
    endcase
  endfunction

  function automatic int exp_low(input logic [11:0] m);
    for (int i = 0; i < 12; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_start = 1'b1;
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); eoc_clr = 1'b1;
    @(negedge clk); eoc_clr = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin tick(1); t++; end
  endtask

  task automatic wait_start_done(input int max);
    int t = 0;
    while (!busy && t < max) begin tick(1); t++; end
    wait_idle();
  endtask

  task automatic pwm_measure(input int d, input string req);
    int n = 0;
    trig_dly = 8'(d);
    @(negedge clk); pwm_trig = 1'b1;
    @(posedge clk); #1; pwm_trig = 1'b0;
    while (!conv_sample && n < 3000) begin @(posedge clk); #1; n++; end
    chk(req, n, 4 * d + 1);
    wait_idle();
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int base;
    bit ev, eo, ee;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; conv_en = 0; irq_en = 0; hw_trig_en = 0; edge_rise = 1;
    trig_sel = 0; trig_dly = 0; smp_code = 0; chan_mask = 0;
    sw_start = 0; start_pin = 0; pwm_trig = 0; rd_strobe = 0; eoc_clr = 0;
    tick(5);
    rst_n = 1'b1;
    tick(2);

    // reset state
    chk("R1 reset busy", busy, 0);
    chk("R9 reset valid", valid, 0);
    chk("R9 reset overrun", overrun, 0);
    chk("R10 reset eoc", eoc_flag, 0);
    chk("R10 reset irq", irq, 0);

    // R1: disabled converter ignores start
    chan_mask = 12'b0110;
    pulse_sw(); tick(10);
    chk("R1 start ignored while disabled", nsamp, 0);
    chk("R1 busy low while disabled", busy, 0);

    // R1/R6/R8/R9/R10: first conversion
    conv_en = 1; irq_en = 1; smp_code = 0;
    pulse_sw();
    chk("R1 busy after start", busy, 1);
    chk("R6 lowest channel", cur_chan, 1);
    wait_idle();
    chk("R8 window code 0", last_smp, 6);
    chk("R9 result loaded", result, mdata);
    chk("R9 valid set", valid, 1);
    chk("R9 no overrun", overrun, 0);
    chk("R10 eoc set", eoc_flag, 1);
    chk("R10 irq raised", irq, 1);

    // R9: overrun and read
    pulse_sw(); wait_idle();
    chk("R9 overrun on unread", overrun, 1);
    chk("R9 valid stays", valid, 1);
    base = int'(result);
    pulse_rd(); tick(1);
    chk("R9 read clears valid", valid, 0);
    chk("R9 read clears overrun", overrun, 0);
    chk("R9 read keeps result", result, base);

    // R10: clear and interrupt enable
    pulse_clr(); tick(1);
    chk("R10 clear eoc", eoc_flag, 0);
    chk("R10 irq drops", irq, 0);
    irq_en = 0;
    pulse_sw(); wait_idle();
    chk("R10 eoc without irq_en", eoc_flag, 1);
    chk("R10 irq masked", irq, 0);
    pulse_clr(); pulse_rd(); irq_en = 1;

    // R7: empty mask
    chan_mask = 0; base = nsamp;
    pulse_sw(); tick(1);
    chk("R7 empty mask busy", busy, 0);
    tick(10);
    chk("R7 empty mask no window", nsamp, base);
    chk("R7 empty mask no eoc", eoc_flag, 0);
    chk("R7 empty mask no valid", valid, 0);

    // R11: starts while busy ignored
    chan_mask = 12'h800; smp_code = 7; base = nsamp;
    pulse_sw(); tick(5); pulse_sw(); tick(20); pulse_sw();
    wait_idle(); tick(10);
    chk("R11 single window", nsamp, base + 1);
    chk("R6 top channel", cur_chan, 11);
    pulse_rd(); pulse_clr();

    // R8: every code
    for (int c = 0; c < 16; c++) begin
      smp_code = 4'(c);
      chan_mask = 12'(1 << (c % 12));
      pulse_sw(); wait_idle();
      chk("R8 window length", last_smp, exp_smp(c));
    end
    pulse_rd(); pulse_clr();

    // R2/R3: pin triggers
    chan_mask = 12'h001; smp_code = 0;
    hw_trig_en = 1; trig_sel = 0; edge_rise = 1;
    base = nsamp;
    @(negedge clk); start_pin = 1; tick(2); start_pin = 0; tick(20);
    chk("R3 short pulse ignored", nsamp, base);
    start_pin = 1; wait_start_done(20); tick(2);
    chk("R2 rising edge starts", nsamp, base + 1);
    start_pin = 0; tick(20);
    chk("R2 falling ignored in rise mode", nsamp, base + 1);
    edge_rise = 0;
    start_pin = 1; tick(20);
    chk("R2 rising ignored in fall mode", nsamp, base + 1);
    start_pin = 0; wait_start_done(20); tick(2);
    chk("R2 falling edge starts", nsamp, base + 2);
    hw_trig_en = 0;
    start_pin = 1; tick(20); start_pin = 0; tick(20);
    chk("R2 pin ignored when disabled", nsamp, base + 2);

    // R4/R5: PWM trigger delay
    hw_trig_en = 1; trig_sel = 3;
    pwm_measure(0, "R4 delay 0");
    pwm_measure(1, "R4 delay 1");
    pwm_measure(5, "R4 delay 5");
    pwm_measure(37, "R4 delay 37");
    base = nsamp; trig_dly = 8'd50;
    @(negedge clk); pwm_trig = 1;
    @(negedge clk); pwm_trig = 0;
    tick(20); hw_trig_en = 0; tick(250);
    chk("R5 cancel no window", nsamp, base);
    chk("R5 cancel busy low", busy, 0);
    trig_sel = 0;
    pulse_rd(); pulse_clr();

    // random rounds, flags predicted by bench model
    ev = 0; eo = 0; ee = 0;
    for (int k = 0; k < 40; k++) begin
      logic [11:0] m;
      int code;
      m = 12'($urandom);
      if (($urandom % 5) == 0) m = '0;
      code = int'($urandom % 8);
      irq_en = 1'($urandom);
      chan_mask = m; smp_code = 4'(code);
      base = nsamp;
      pulse_sw(); wait_idle(); tick(2);
      if (m == 0) begin
        chk("R7 random empty", nsamp, base);
      end else begin
        eo = ev | eo; ev = 1; ee = 1;
        chk("R6 random channel", cur_chan, exp_low(m));
        chk("R8 random window", last_smp, exp_smp(code));
        chk("R9 random result", result, mdata);
      end
      chk("R9 random valid", valid, ev);
      chk("R9 random overrun", overrun, eo);
      chk("R10 random irq", irq, ee & irq_en);
      if ($urandom % 2) begin pulse_rd(); ev = 0; eo = 0; end
      if ($urandom % 2) begin pulse_clr(); ee = 0; end
      tick(1);
      chk("R9 random valid after read", valid, ev);
      chk("R10 random eoc after clear", eoc_flag, ee);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule